// File: doc/BRIEF.md
# Bidirectional Sampling Pulse Sequencer

This block produces the digital sample strobes for a column driver with 480 sample outputs, organised as 160 groups of three colour channels. A start pulse is captured at one end of a 160-stage token chain. Each rising edge of the first phase input then moves the token one group along. While a group holds the token, its three strobes follow the phase inputs. The direction input decides which end accepts the start pulse and which end raises the cascade pulse for the next driver in a chain.

In sequential mode the three phase inputs strobe the three outputs of a group one at a time. The direction also swaps which of phases one and three serves the first and last output of each triple. In simultaneous mode phase one alone strobes the whole triple, and the other two phases have no effect. A separate bank-select input states which of two hold banks is sampling and which is driving.

The phase inputs are ordinary level signals, sampled by the system clock. Strobes and cascade outputs change one system clock after the phase input that causes them.

Top module: `sample_strobe_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the token chain and both cascade outputs are cleared. After reset, every strobe and both cascade outputs read 0.
- R2: With `dir_right_i` high, a high `start_r_i` seen at a rising edge of `phase_i[0]` makes group 1 (outputs 1..3, strobe bits 0..2) active. Each later rise moves the token from group n to group n+1. A start seen while a token is already in the chain restarts the chain at group 1.
- R3: With `dir_right_i` low, a high `start_l_i` seen at a rising edge of `phase_i[0]` makes group 160 (strobe bits 477..479) active. Each later rise moves the token from group n to group n-1.
- R4: The start input at the exit end (`start_l_i` for right shift, `start_r_i` for left shift) has no effect, even when it is held high for a whole line.
- R5: A rising edge of `phase_i[0]` that moves the token out of the last stage raises the exit-end cascade output. That is `carry_l_o` for right shift and `carry_r_o` for left shift. The output stays high until the next rise of `phase_i[0]`, and the other cascade output stays low. A new start captured on that same rise is still accepted.
- R6: In sequential mode (`mode_simul_i` low) with right shift, for the active group n, `phase_i[0]` strobes output 3n-2, `phase_i[1]` strobes output 3n-1 and `phase_i[2]` strobes output 3n.
- R7: In sequential mode with left shift, `phase_i[0]` strobes output 3n, `phase_i[1]` strobes output 3n-1 and `phase_i[2]` strobes output 3n-2.
- R8: In simultaneous mode (`mode_simul_i` high), `phase_i[0]` strobes all three outputs of the active group together, and `phase_i[1]` and `phase_i[2]` have no effect on any strobe.
- R9: At most one group is active at a time. Strobes of inactive groups are low, and once the token has left the chain all strobes stay low until the next start.
- R10: `hold_bank_o` bit 0 set means hold bank 1 samples, and bit 1 set means hold bank 2 samples. `bank_sel_i` high gives 2'b01 and low gives 2'b10, with no clock delay.
- R11: A strobe follows its phase input with a latency of exactly one system clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_right_i | input | 1 | 1: token runs from group 1 to group 160; 0: the reverse |
| mode_simul_i | input | 1 | 1: simultaneous sampling; 0: sequential sampling |
| bank_sel_i | input | 1 | Hold-bank role select |
| phase_i | input | 3 | Phase levels; bit 0 also advances the token |
| start_r_i | input | 1 | Start pulse at the group-1 end |
| start_l_i | input | 1 | Start pulse at the group-160 end |
| carry_r_o | output | 1 | Cascade pulse at the group-1 end (left shift) |
| carry_l_o | output | 1 | Cascade pulse at the group-160 end (right shift) |
| strobe_o | output | 480 | Sample strobes; bit k is output k+1 |
| hold_bank_o | output | 2 | One-hot flag of the sampling hold bank |

## Verification
Two functions can land on the same rise of phase one: the token leaving the final group, which must raise the cascade output, and a new start pulse, which must reload the entry group. The bench provokes this by running a full line of 160 advances and raising the start input exactly on the rise that pushes the token out. It then expects the cascade output high and the first group's strobes active in that same cycle. A mid-line restart and the same sweep in both directions and both modes show that the reload never leaves a second token behind.

// File: rtl/sss_pkg.sv
// Package: shared constants and the configuration record for the
// sampling pulse sequencer. Assumes exactly three colour channels per group.
package sss_pkg;

    localparam int PHASES = 3;

    typedef struct packed {
        logic right;  // token runs from group 1 upward
        logic simul;  // phase 0 strobes the whole triple
    } seq_cfg_t;

endpackage

// File: rtl/sss_phase_edge.sv
// Module: registers the phase levels in the system clock domain and flags
// a rising edge on each phase. Assumes each phase input is held stable for
// at least one system clock period between changes.
module sss_phase_edge #(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] ph_i,
    output logic [NPH-1:0] ph_lvl_o,
    output logic [NPH-1:0] ph_rise_o
);

    logic [NPH-1:0] ph_q;

    // Purpose: keep the previous phase levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_i;
    end

    // Purpose: a rise is a high input that was low one clock earlier.
    always_comb begin
        ph_rise_o = ph_i & ~ph_q;
        ph_lvl_o  = ph_q;
    end

    // R11: a detected rise shows up as a high level on the next clock.
    p_rise_to_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ph_rise_o[0] |=> ph_lvl_o[0]);

endmodule

// File: rtl/sss_token_chain.sv
// Module: single-token shift register over the groups plus the two
// cascade outputs. Moves only on an advance pulse. A start at the entry
// end reloads the chain, so at most one token exists at any time.
module sss_token_chain #(
    parameter int GROUPS = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              dir_right_i,
    input  logic              start_r_i,
    input  logic              start_l_i,
    output logic [GROUPS-1:0] tok_o,
    output logic              carry_r_o,
    output logic              carry_l_o
);

    localparam int LAST = GROUPS - 1;

    logic [GROUPS-1:0] tok_q;
    logic [GROUPS-1:0] shifted;
    logic [GROUPS-1:0] entry;
    logic [GROUPS-1:0] tok_next;
    logic              start_in;
    logic              exit_bit;
    logic              carry_r_q;
    logic              carry_l_q;

    // Purpose: pick the active start pin, the exit bit and the next chain value.
    always_comb begin
        start_in = dir_right_i ? start_r_i : start_l_i;
        exit_bit = dir_right_i ? tok_q[LAST] : tok_q[0];
        shifted  = dir_right_i ? {tok_q[LAST-1:0], 1'b0} : {1'b0, tok_q[LAST:1]};
        entry    = '0;
        if (dir_right_i) entry[0]    = 1'b1;
        else             entry[LAST] = 1'b1;
        tok_next = start_in ? entry : shifted;
    end

    // Purpose: advance the chain and capture the cascade pulse on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q     <= '0;
            carry_r_q <= 1'b0;
            carry_l_q <= 1'b0;
        end else if (adv_i) begin
            tok_q     <= tok_next;
            carry_l_q <= dir_right_i & exit_bit;
            carry_r_q <= ~dir_right_i & exit_bit;
        end
    end

    assign tok_o     = tok_q;
    assign carry_r_o = carry_r_q;
    assign carry_l_o = carry_l_q;

    p_single_token_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok_q));

    p_step_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && dir_right_i && !start_in && tok_q[0]) |=> tok_q[1]);

    p_step_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !dir_right_i && !start_in && tok_q[LAST]) |=> tok_q[LAST-1]);

    p_exit_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && dir_right_i && tok_q[LAST]) |=> (carry_l_o && !carry_r_o));

    p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(carry_l_o) && $stable(carry_r_o)));

endmodule

// File: rtl/sss_strobe_map.sv
// Module: turns the active-group token and the registered phase levels into
// the three strobes of every group. Sequential mode swaps the outer phases
// with direction; simultaneous mode drives the whole triple from phase 0.
module sss_strobe_map #(
    parameter int GROUPS = 160
) (
    input  logic [GROUPS-1:0]   tok_i,
    input  logic [2:0]          ph_lvl_i,
    input  sss_pkg::seq_cfg_t   cfg_i,
    output logic [3*GROUPS-1:0] strobe_o
);

    logic en_first;
    logic en_mid;
    logic en_last;

    // Purpose: choose which phase drives each position within a triple.
    always_comb begin
        en_first = cfg_i.simul ? ph_lvl_i[0] : (cfg_i.right ? ph_lvl_i[0] : ph_lvl_i[2]);
        en_mid   = cfg_i.simul ? ph_lvl_i[0] : ph_lvl_i[1];
        en_last  = cfg_i.simul ? ph_lvl_i[0] : (cfg_i.right ? ph_lvl_i[2] : ph_lvl_i[0]);
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign strobe_o[3*g]     = tok_i[g] & en_first;
        assign strobe_o[3*g + 1] = tok_i[g] & en_mid;
        assign strobe_o[3*g + 2] = tok_i[g] & en_last;
    end

endmodule

// File: rtl/sample_strobe_seq.sv
// Module: top of the sampling pulse sequencer. It samples the phase inputs,
// moves the token on each rise of phase 0 and maps it to 3*GROUPS strobes.
// The hold-bank select is passed straight through as a one-hot flag.
// Assumes the phase inputs change slowly compared with clk.
module sample_strobe_seq #(
    parameter int GROUPS = 160
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_right_i,
    input  logic                mode_simul_i,
    input  logic                bank_sel_i,
    input  logic [2:0]          phase_i,
    input  logic                start_r_i,
    input  logic                start_l_i,
    output logic                carry_r_o,
    output logic                carry_l_o,
    output logic [3*GROUPS-1:0] strobe_o,
    output logic [1:0]          hold_bank_o
);

    import sss_pkg::*;

    logic [PHASES-1:0] ph_lvl;
    logic [PHASES-1:0] ph_rise;
    logic [GROUPS-1:0] tok;
    seq_cfg_t          cfg;

    // Purpose: bundle the static configuration inputs.
    always_comb begin
        cfg.right = dir_right_i;
        cfg.simul = mode_simul_i;
    end

    // Purpose: bank 1 samples when the select is high, bank 2 otherwise.
    always_comb hold_bank_o = {~bank_sel_i, bank_sel_i};

    sss_phase_edge #(.NPH(PHASES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_i      (phase_i),
        .ph_lvl_o  (ph_lvl),
        .ph_rise_o (ph_rise)
    );

    sss_token_chain #(.GROUPS(GROUPS)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (ph_rise[0]),
        .dir_right_i (dir_right_i),
        .start_r_i   (start_r_i),
        .start_l_i   (start_l_i),
        .tok_o       (tok),
        .carry_r_o   (carry_r_o),
        .carry_l_o   (carry_l_o)
    );

    sss_strobe_map #(.GROUPS(GROUPS)) u_map (
        .tok_i    (tok),
        .ph_lvl_i (ph_lvl),
        .cfg_i    (cfg),
        .strobe_o (strobe_o)
    );

    p_triple_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe_o) <= 3);

    p_simul_triple_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_simul_i && ph_lvl[0] && (|tok)) |-> ($countones(strobe_o) == 3));

    p_simul_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_simul_i && !ph_lvl[0]) |-> (strobe_o == '0));

    p_seq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_simul_i && $onehot0(ph_lvl)) |-> ($countones(strobe_o) <= 1));

    p_bank_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(hold_bank_o));

endmodule

// File: tb/tb_sample_strobe_seq.sv
module tb_sample_strobe_seq;

    localparam int G = 160;
    localparam int N = 3 * G;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         dir_right;
    logic         mode_simul;
    logic         bank_sel;
    logic [2:0]   phase;
    logic         start_r;
    logic         start_l;
    logic         carry_r;
    logic         carry_l;
    logic [N-1:0] strobe;
    logic [1:0]   hold_bank;

    int   n_chk = 0;
    int   n_fail = 0;
    int   exp_grp = -1;
    logic exp_cr = 1'b0;
    logic exp_cl = 1'b0;
    logic [2:0] cur_ph = 3'b000;
    bit   done = 0;

    always #4 clk = ~clk;

    sample_strobe_seq #(.GROUPS(G)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dir_right_i  (dir_right),
        .mode_simul_i (mode_simul),
        .bank_sel_i   (bank_sel),
        .phase_i      (phase),
        .start_r_i    (start_r),
        .start_l_i    (start_l),
        .carry_r_o    (carry_r),
        .carry_l_o    (carry_l),
        .strobe_o     (strobe),
        .hold_bank_o  (hold_bank)
    );

    function automatic logic [N-1:0] exp_strobe();
        logic [N-1:0] v = '0;
        if (exp_grp >= 0) begin
            if (mode_simul) begin
                v[3*exp_grp]     = cur_ph[0];
                v[3*exp_grp + 1] = cur_ph[0];
                v[3*exp_grp + 2] = cur_ph[0];
            end else begin
                v[3*exp_grp]     = dir_right ? cur_ph[0] : cur_ph[2];
                v[3*exp_grp + 1] = cur_ph[1];
                v[3*exp_grp + 2] = dir_right ? cur_ph[2] : cur_ph[0];
            end
        end
        return v;
    endfunction

    task automatic check(input string tag);
        logic [N-1:0] e;
        e = exp_strobe();
        n_chk++;
        if (strobe !== e || carry_r !== exp_cr || carry_l !== exp_cl) begin
            n_fail++;
            $display("FAIL %s strobe act=%h exp=%h carry_r/l act=%b%b exp=%b%b",
                     tag, strobe, e, carry_r, carry_l, exp_cr, exp_cl);
        end
    endtask

    // Drive one phase pattern after a falling edge, update the model, check one clock later.
    task automatic drive(input logic [2:0] p, input logic sr, input logic sl, input string tag);
        int exit_g;
        logic st;
        phase   = p;
        start_r = sr;
        start_l = sl;
        if (p[0] && !cur_ph[0]) begin
            exit_g = dir_right ? G - 1 : 0;
            exp_cl = dir_right && (exp_grp == exit_g);
            exp_cr = !dir_right && (exp_grp == exit_g);
            st     = dir_right ? sr : sl;
            if (st)                  exp_grp = dir_right ? 0 : G - 1;
            else if (exp_grp == exit_g) exp_grp = -1;
            else if (exp_grp >= 0)   exp_grp = dir_right ? exp_grp + 1 : exp_grp - 1;
        end
        cur_ph = p;
        @(negedge clk);
        check(tag);
    endtask

    // One full phase period: each phase high then low, each state checked.
    task automatic ph_cycle(input logic sr, input logic sl, input string tag);
        drive(3'b001, sr, sl, tag);
        drive(3'b000, 1'b0, dir_right ? sl : 1'b0, tag);
        drive(3'b010, 1'b0, dir_right ? sl : 1'b0, tag);
        drive(3'b000, 1'b0, dir_right ? sl : 1'b0, tag);
        drive(3'b100, dir_right ? 1'b0 : sr, dir_right ? sl : 1'b0, tag);
        drive(3'b000, dir_right ? 1'b0 : sr, dir_right ? sl : 1'b0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        phase = 3'b000;
        start_r = 1'b0;
        start_l = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_grp = -1;
        exp_cr = 1'b0;
        exp_cl = 1'b0;
        cur_ph = 3'b000;
        @(negedge clk);
        check("R1 reset state");
    endtask

    // Full line sweep; the exit-end start input is held high throughout (R4).
    task automatic run_sweep(input logic d, input logic m, input string tag);
        dir_right = d;
        mode_simul = m;
        do_reset();
        for (int k = 0; k < G + 2; k++) begin
            if (d) ph_cycle(k == 0, 1'b1, tag);
            else   ph_cycle(1'b1, k == 0, tag);
        end
    endtask

    task automatic test_mid_reset();
        dir_right = 1'b1;
        mode_simul = 1'b0;
        do_reset();
        for (int k = 0; k < 6; k++) ph_cycle(k == 0, 1'b0, "R2 pre-reset run");
        drive(3'b001, 1'b0, 1'b0, "R2 pre-reset run");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        phase = 3'b000;
        exp_grp = -1;
        exp_cr = 1'b0;
        exp_cl = 1'b0;
        cur_ph = 3'b000;
        @(negedge clk);
        check("R1 reset mid-line");
        ph_cycle(1'b0, 1'b0, "R1 R9 idle after reset");
    endtask

    task automatic test_restart();
        dir_right = 1'b1;
        mode_simul = 1'b0;
        do_reset();
        for (int k = 0; k < 12; k++) ph_cycle(k == 0 || k == 9, 1'b0, "R2 R9 restart mid-line");
        n_chk++;
        if (exp_grp != 2) begin
            n_fail++;
            $display("FAIL R2 model group act=%0d exp=2", exp_grp);
        end
    endtask

    task automatic test_back_to_back();
        dir_right = 1'b1;
        mode_simul = 1'b0;
        do_reset();
        for (int k = 0; k < G; k++) ph_cycle(k == 0, 1'b0, "R5 line run");
        drive(3'b001, 1'b1, 1'b0, "R5 exit and start on one rise");
        n_chk++;
        if (!(carry_l === 1'b1 && strobe[0] === 1'b1)) begin
            n_fail++;
            $display("FAIL R5 same-rise carry_l act=%b exp=1 strobe0 act=%b exp=1", carry_l, strobe[0]);
        end
        drive(3'b000, 1'b0, 1'b0, "R5 R6 next line");
        ph_cycle(1'b0, 1'b0, "R5 carry drop");
    endtask

    task automatic test_bank();
        bank_sel = 1'b1;
        #1;
        n_chk++;
        if (hold_bank !== 2'b01) begin
            n_fail++;
            $display("FAIL R10 hold_bank act=%b exp=01", hold_bank);
        end
        bank_sel = 1'b0;
        #1;
        n_chk++;
        if (hold_bank !== 2'b10) begin
            n_fail++;
            $display("FAIL R10 hold_bank act=%b exp=10", hold_bank);
        end
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        dir_right = 1'b1;
        mode_simul = 1'b0;
        bank_sel = 1'b0;
        phase = 3'b000;
        start_r = 1'b0;
        start_l = 1'b0;
        @(negedge clk);
        do_reset();
        test_bank();
        run_sweep(1'b1, 1'b0, "R2 R4 R5 R6 R9 R11 right sequential");
        run_sweep(1'b0, 1'b0, "R3 R4 R5 R7 R9 R11 left sequential");
        run_sweep(1'b1, 1'b1, "R2 R4 R5 R8 R9 right simultaneous");
        run_sweep(1'b0, 1'b1, "R3 R4 R5 R8 R9 left simultaneous");
        test_restart();
        test_back_to_back();
        test_mid_reset();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule